// File: doc/BRIEF.md
# Ternary Array Boot Configuration Loader

This block configures a ternary programmable array whenever it comes out of reset. The array has no non-volatile storage. Its configuration therefore lives in an ordinary binary serial memory on an SPI bus. The loader is the bus master and drives the serial clock. It lowers chip-select, sends a read command with a start address of zero, and then clocks in a fixed number of configuration bits. Each bit goes out on a data line together with a single-cycle shift strobe, which feeds the array's configuration chain. That chain behaves as one long shift register.

A single three-level mode pin controls the block. The pin is presented as a two-bit signed code. Positive selects reset: the loader stays idle and restarts the load when the pin leaves that value. Zero selects normal operation. Negative selects programming. A load runs in either of the two non-reset modes. Once the last bit is in, the loader raises its done flag and releases the bus one serial-clock period later. When the pin is at zero and done is high, control passes to the loaded design.

Top module: `cfg_boot_loader`

## Requirements
- R1: `mode_i` is decoded as follows: 2'b01 means +1 (reset), 2'b00 means 0 (run), 2'b11 means -1 (program), and the unused code 2'b10 is treated as reset. The decoded mode is registered, so it takes effect one clock after it is sampled.
- R2: While reset is selected, `spi_cs_no` is high, `spi_sck_o` is low, `cfg_done_o` is low and no strobe is issued. Leaving reset for run or program starts a load.
- R3: A load lowers `spi_cs_no` and sends 32 bits MSB first on `spi_mosi_o`: the byte 0x03 followed by a 24-bit address of zero. MOSI changes only while SCK is low.
- R4: SCK idles low (SPI mode 0). While a load is active, SCK has a period of 2*HALF_DIV system clocks.
- R5: After the 32 header bits, `spi_miso_i` is sampled at every rising SCK edge. Each sample appears on `cfg_data_o` with a one-cycle `cfg_shift_o` pulse, in the order received (the image MSB first).
- R6: A load produces exactly CHAIN_LEN strobes, and none follow once the load is done.
- R7: `cfg_done_o` rises in the same cycle as the last strobe and stays high until reset is selected.
- R8: `spi_cs_no` rises 2*HALF_DIV clocks after `cfg_done_o` rises. SCK is low whenever chip-select is high.
- R9: `user_run_o` is high exactly when `cfg_done_o` is high and the decoded mode is run. It stays low in program mode.
- R10: Selecting reset during a load aborts that load. The next load restarts from the command byte and delivers the full image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Three-level mode code (see R1) |
| spi_sck_o | output | 1 | Serial clock to the memory |
| spi_cs_no | output | 1 | Active-low chip-select |
| spi_mosi_o | output | 1 | Command and address bits to the memory |
| spi_miso_i | input | 1 | Data bits from the memory |
| cfg_data_o | output | 1 | Configuration bit for the chain |
| cfg_shift_o | output | 1 | One-cycle shift strobe for the chain |
| cfg_done_o | output | 1 | Configuration complete |
| user_run_o | output | 1 | Loaded design is in control |

## Verification
The bench builds the loader with HALF_DIV=2 and CHAIN_LEN=20. This keeps one load to about 210 clocks, so a sweep of images can be run end to end: all zeros, all ones, both alternating patterns, end-bit patterns and a mixed pattern. The loads alternate between program and run modes. A behavioural memory model in the bench answers the command and records the header that reaches it. These parameter values also bring a mid-data abort, the unused mode code and the run handover after a program-mode load within a short run. With them, the 2*HALF_DIV release delay and SCK period can be counted exactly.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DATA,
    ST_DONE
  } ld_state_e;

  localparam logic [7:0] READ_OP = 8'h03;
  localparam int unsigned CMD_W  = 8;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned HDR_W  = CMD_W + ADDR_W;

  localparam logic [1:0] TRIT_ZERO = 2'b00;
  localparam logic [1:0] TRIT_POS  = 2'b01;
  localparam logic [1:0] TRIT_NEG  = 2'b11;
endpackage

// File: rtl/cbl_mode_dec.sv
module cbl_mode_dec
  import cbl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  output logic       hold_rst_o,
  output logic       run_o,
  output logic       prog_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_rst_o <= 1'b1;
      run_o      <= 1'b0;
      prog_o     <= 1'b0;
    end else begin
      run_o      <= (mode_i == TRIT_ZERO);
      prog_o     <= (mode_i == TRIT_NEG);
      // unused code falls into reset
      hold_rst_o <= (mode_i != TRIT_ZERO) && (mode_i != TRIT_NEG);
    end
  end

  // R1
  bad_code_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10) |=> (hold_rst_o && !run_o && !prog_o));

  // R1
  pos_code_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == TRIT_POS) |=> hold_rst_o);

endmodule

// File: rtl/cbl_sck_gen.sv
module cbl_sck_gen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic hold_low_i,
  output logic tick_o,
  output logic sck_o
);

  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && !clr_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
      if (sck_o)            sck_o <= 1'b0;
      else if (!hold_low_i) sck_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8
  hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_low_i && !sck_o) |=> !sck_o);

  // R2
  clr_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !sck_o);

endmodule

// File: rtl/cbl_seq.sv
module cbl_seq
  import cbl_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_rst_i,
  input  logic tick_i,
  input  logic sck_i,
  input  logic miso_i,
  output logic sck_run_o,
  output logic sck_hold_o,
  output logic cs_no,
  output logic mosi_o,
  output logic cfg_data_o,
  output logic cfg_shift_o,
  output logic done_o
);

  localparam int unsigned MAX_CNT = (CHAIN_LEN > ADDR_W) ? CHAIN_LEN : ADDR_W;
  localparam int unsigned BIT_W   = $clog2(MAX_CNT + 1);
  localparam logic [BIT_W-1:0] CMD_LAST  = BIT_W'(CMD_W - 1);
  localparam logic [BIT_W-1:0] ADDR_LAST = BIT_W'(ADDR_W - 1);
  localparam logic [BIT_W-1:0] DATA_LAST = BIT_W'(CHAIN_LEN - 1);

  ld_state_e        state_q;
  logic [BIT_W-1:0] bit_cnt_q;
  logic [HDR_W-1:0] tx_q;
  logic             rise, fall;

  assign rise       = tick_i && !sck_i && (state_q != ST_DONE);
  assign fall       = tick_i && sck_i;
  assign sck_run_o  = (state_q != ST_IDLE) && !cs_no;
  assign sck_hold_o = (state_q == ST_DONE);
  assign mosi_o     = tx_q[HDR_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      tx_q        <= '0;
      cs_no       <= 1'b1;
      cfg_data_o  <= 1'b0;
      cfg_shift_o <= 1'b0;
      done_o      <= 1'b0;
    end else if (hold_rst_i) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      cs_no       <= 1'b1;
      cfg_shift_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      cfg_shift_o <= 1'b0;
      if (fall) tx_q <= {tx_q[HDR_W-2:0], 1'b0};
      unique case (state_q)
        ST_IDLE: begin
          state_q   <= ST_CMD;
          cs_no     <= 1'b0;
          bit_cnt_q <= '0;
          tx_q      <= {READ_OP, {ADDR_W{1'b0}}};
        end
        ST_CMD: if (rise) begin
          if (bit_cnt_q == CMD_LAST) begin
            state_q   <= ST_ADDR;
            bit_cnt_q <= '0;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        ST_ADDR: if (rise) begin
          if (bit_cnt_q == ADDR_LAST) begin
            state_q   <= ST_DATA;
            bit_cnt_q <= '0;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        ST_DATA: if (rise) begin
          cfg_data_o  <= miso_i;
          cfg_shift_o <= 1'b1;
          if (bit_cnt_q == DATA_LAST) begin
            state_q <= ST_DONE;
            done_o  <= 1'b1;
          end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        ST_DONE: begin
          // the tick that would raise SCK releases the bus instead
          if (tick_i && !sck_i && !cs_no) cs_no <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R7
  done_with_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> cfg_shift_o);

  // R6
  no_late_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> !cfg_shift_o);

  // R2
  rst_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_rst_i |=> (state_q == ST_IDLE && cs_no && !done_o));

  // R3
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_i && $past(sck_i)) |-> $stable(mosi_o));

endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader #(
  parameter int unsigned HALF_DIV  = 2,
  parameter int unsigned CHAIN_LEN = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  output logic       spi_sck_o,
  output logic       spi_cs_no,
  output logic       spi_mosi_o,
  input  logic       spi_miso_i,
  output logic       cfg_data_o,
  output logic       cfg_shift_o,
  output logic       cfg_done_o,
  output logic       user_run_o
);

  logic hold_rst, mode_run, mode_prog;
  logic tick, sck_run, sck_hold;

  cbl_mode_dec u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode_i),
    .hold_rst_o (hold_rst),
    .run_o      (mode_run),
    .prog_o     (mode_prog)
  );

  cbl_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (hold_rst),
    .run_i      (sck_run),
    .hold_low_i (sck_hold),
    .tick_o     (tick),
    .sck_o      (spi_sck_o)
  );

  cbl_seq #(.CHAIN_LEN(CHAIN_LEN)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hold_rst_i  (hold_rst),
    .tick_i      (tick),
    .sck_i       (spi_sck_o),
    .miso_i      (spi_miso_i),
    .sck_run_o   (sck_run),
    .sck_hold_o  (sck_hold),
    .cs_no       (spi_cs_no),
    .mosi_o      (spi_mosi_o),
    .cfg_data_o  (cfg_data_o),
    .cfg_shift_o (cfg_shift_o),
    .done_o      (cfg_done_o)
  );

  assign user_run_o = cfg_done_o && mode_run;

  // R8
  cs_idle_sck_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o);

  // R9
  prog_no_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_prog |-> !user_run_o);

endmodule

// File: tb/cfg_boot_loader_tb.sv
module cfg_boot_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int N = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b01;
  logic miso = 1'b0;
  logic sck, cs_n, mosi, cdata, cshift, done, urun;

  int checks = 0;
  int errors = 0;
  bit sim_end = 0;

  logic [N-1:0] image = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_boot_loader #(.HALF_DIV(HALF), .CHAIN_LEN(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .spi_sck_o(sck), .spi_cs_no(cs_n), .spi_mosi_o(mosi), .spi_miso_i(miso),
    .cfg_data_o(cdata), .cfg_shift_o(cshift), .cfg_done_o(done), .user_run_o(urun)
  );

  // memory model and monitor, evaluated between active edges
  int cyc = 0, rx_cnt = 0, dcnt = 0, sh_cnt = 0, last_rise = -1;
  int done_cyc = -1, rel_cyc = -1;
  logic [31:0] rx_sh = '0;
  logic [N-1:0] got = '0;
  bit late_shift = 0, done_alone = 0, per_bad = 0, mosi_bad = 0, idle_bad = 0;
  logic p_cs = 1'b1, p_sck = 1'b0, p_mosi = 1'b0, p_done = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_cs && !cs_n) begin
        rx_cnt = 0; dcnt = 0; sh_cnt = 0; rx_sh = '0; got = '0;
        late_shift = 0; done_alone = 0; per_bad = 0; mosi_bad = 0;
        last_rise = -1; done_cyc = -1; rel_cyc = -1; miso = 1'b0;
      end
      if (!p_sck && sck && !cs_n) begin
        if (rx_cnt < 32) begin
          rx_sh = {rx_sh[30:0], mosi};
          rx_cnt++;
        end
        if (last_rise >= 0 && (cyc - last_rise) != 2*HALF) per_bad = 1;
        last_rise = cyc;
      end
      if (p_sck && !sck && !cs_n && rx_cnt >= 32) begin
        miso = (dcnt < N) ? image[N-1-dcnt] : 1'b0;
        dcnt++;
      end
      if (sck && p_sck && mosi != p_mosi) mosi_bad = 1;
      if (cs_n && sck) idle_bad = 1;
      if (cshift) begin
        got = {got[N-2:0], cdata};
        sh_cnt++;
        if (p_done) late_shift = 1;
      end
      if (done && !p_done) begin
        done_cyc = cyc;
        if (!cshift) done_alone = 1;
      end
      if (cs_n && !p_cs && done_cyc >= 0) rel_cyc = cyc;
    end
    p_cs = cs_n; p_sck = sck; p_mosi = mosi; p_done = done;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (2*HALF + 4) @(negedge clk);
  endtask

  task automatic run_load(input logic [N-1:0] img, input logic [1:0] md);
    @(negedge clk);
    mode = 2'b01;
    repeat (3) @(negedge clk);
    image = img;
    mode = md;
    wait_done();
    // R3 command 0x03 then zero address
    chk(rx_sh == 32'h0300_0000, "R3 header", rx_sh, 32'h0300_0000);
    chk(!mosi_bad, "R3 mosi moved while sck high", mosi_bad, 0);
    // R4
    chk(!per_bad, "R4 sck period", per_bad, 0);
    // R5
    chk(got == img, "R5 image bits", got, img);
    // R6
    chk(sh_cnt == N, "R6 strobe count", sh_cnt, N);
    chk(!late_shift, "R6 strobe after done", late_shift, 0);
    // R7
    chk(done && !done_alone, "R7 done with last strobe", {done, done_alone}, 2'b10);
    // R8
    chk(rel_cyc - done_cyc == 2*HALF, "R8 release delay", rel_cyc - done_cyc, 2*HALF);
    chk(cs_n && !sck && !idle_bad, "R8 bus idle", {cs_n, sck, idle_bad}, 3'b100);
    // R9
    chk(urun == (md == 2'b00), "R9 handover", urun, (md == 2'b00));
  endtask

  initial begin
    logic [N-1:0] pats [6];
    pats[0] = 20'h00000; pats[1] = 20'hFFFFF; pats[2] = 20'hAAAAA;
    pats[3] = 20'h55555; pats[4] = 20'h80001; pats[5] = 20'h3C5A9;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R2 reset state held while mode is +1
    chk(cs_n && !sck && !done && !cshift && !urun, "R2 reset hold",
        {cs_n, sck, done, cshift, urun}, 5'b10000);
    for (int i = 0; i < 6; i++) run_load(pats[i], (i % 2 == 0) ? 2'b11 : 2'b00);

    // R9 program-mode load then switch to run
    run_load(20'h6E2D1, 2'b11);
    chk(!urun, "R9 no run in program mode", urun, 0);
    mode = 2'b00;
    repeat (2) @(negedge clk);
    chk(urun && done, "R9 run after switch", {urun, done}, 2'b11);

    // R1 unused code acts as reset
    mode = 2'b10;
    repeat (3) @(negedge clk);
    chk(!done && cs_n && !urun, "R1 code 2'b10 resets", {done, cs_n, urun}, 3'b010);
    repeat (8) @(negedge clk);
    chk(cs_n && !sck, "R1 code 2'b10 stays idle", {cs_n, sck}, 2'b10);

    // R10 abort mid-data, then restart
    mode = 2'b01;
    repeat (3) @(negedge clk);
    image = 20'hC3A5F;
    mode = 2'b11;
    repeat (4*(32 + 6)) @(negedge clk);
    chk(sh_cnt > 0 && sh_cnt < N && !done, "R10 abort point inside data", sh_cnt, 6);
    mode = 2'b01;
    repeat (3) @(negedge clk);
    chk(cs_n && !sck && !done, "R10 abort idles bus", {cs_n, sck, done}, 3'b100);
    run_load(20'hC3A5F, 2'b00);

    sim_end = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!sim_end) begin
      errors++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule